// File: doc/BRIEF.md
# Pipelined Cuckoo Hash Key-Value Table

This block is an on-chip key-value store organised as a two-way cuckoo hash table. Storage is split into two tables of 2^IDX_W slots. Each slot holds a valid flag, a key and a value, and each table is addressed by its own hash of the key. A lookup port probes the candidate slot in both tables at once and reports hit or miss with the stored value a fixed two cycles later. It takes a new key on every clock cycle and has no back-pressure. The whole block runs on one clock of its own, which is not tied to any network clock.

A second port carries insert and delete requests. It uses a valid/ready handshake. The requester holds `req_valid` and the request fields steady until a cycle in which `req_ready` is high, and the fields are captured at that edge. `req_ready` stays low until the request completes, so only one insert or eviction chain runs at a time and later requests wait. When an insert finds both candidate slots occupied, the new pair takes the slot in table 0. The resident pair is pushed out into a carry register, and from there it moves into its slot in the other table, again and again, until it reaches a free slot or hits the displacement limit. Lookups issued during a chain also compare against the carry register, so the pair in flight never vanishes from view. Each request finishes with a one-cycle `op_done` pulse that carries its status flags.

Top module: `cuckoo_kv`

## Requirements
- R1: The lookup port accepts a key on every cycle in which `lk_valid` is high. `res_valid` is high exactly two clock edges after the edge that sampled `lk_valid`, and low otherwise.
- R2: On a result, `res_hit` is 1 and `res_value` is the stored value if either table (or the carry register) holds the key. Otherwise `res_hit` is 0 and `res_value` is 0.
- R3: Table 0 slot = bits [31:28] of ((k ^ (k >> 16)) * 0x045D9F3B) mod 2^32. Table 1 slot = bits [31:28] of ((k ^ (k >> 13)) * 0x2C1B3C6D) mod 2^32. These are the default widths: KEY_W=32, IDX_W=4.
- R4: An insert of an absent key whose table 0 slot is free goes to table 0. Otherwise, if its table 1 slot is free, it goes to table 1. In both cases `op_done` is seen after the first edge following acceptance, with `op_found`=0 and `op_fail`=0.
- R5: An insert of a key already present replaces its value in place. It reports `op_found`=1, starts no chain and finishes with the same one-edge latency as R4.
- R6: An insert that finds both slots occupied writes the new pair into table 0. The evicted pair then goes to its other table's slot, alternating tables, and each displacement takes one cycle. A chain that needs one relocation finishes two edges after acceptance.
- R7: A chain is aborted after 16 displacements if the last displaced pair finds no free slot. That pair is dropped, `op_fail`=1 and `op_found`=0, and `op_done` comes 17 edges after acceptance.
- R8: `req_ready` is low from the edge after an accepted request until `op_done`, and is high while idle.
- R9: A lookup issued at any time during an eviction chain reports a hit for every stored key, including the pair currently displaced.
- R10: A delete request (`req_del`=1) clears the matching slot and reports `op_found`=1. Afterwards the key misses and all other keys are unchanged. A delete of an absent key reports `op_found`=0 and changes nothing.
- R11: Reset (`rst_n` low) empties both tables, drops any chain and clears all outputs. `req_ready` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Table clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup key valid (always accepted) |
| lk_key | input | KEY_W | Lookup key |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Key was found |
| res_value | output | VAL_W | Value found, 0 on miss |
| req_valid | input | 1 | Insert/delete request valid |
| req_ready | output | 1 | Request port can accept |
| req_del | input | 1 | 1 = delete, 0 = insert |
| req_key | input | KEY_W | Request key |
| req_value | input | VAL_W | Insert value |
| op_done | output | 1 | One-cycle completion pulse |
| op_found | output | 1 | Insert updated an existing key, or delete found its key |
| op_fail | output | 1 | Insert aborted at the displacement limit |

## Verification
The bench builds keys that collide by construction, which forces a one-step eviction. It keeps a lookup of the displaced key running every cycle across that chain. A design with no bypass through the carry register would report one spurious miss in the cycle the pair is in flight, and wrong hashes would change the completion latency. Overfilling the table forces the displacement limit. Here the bench checks the 17-edge latency and that exactly one stored pair is lost, which catches an off-by-one limit or a chain that overwrites a second entry. An update of an existing key must not start a chain, and deleting an absent key must not clear anything. Back-to-back lookups check that the pipeline stays full and aligned.

// File: rtl/cuckoo_kv_pkg.sv
package cuckoo_kv_pkg;
  localparam int N_TBL = 2;

  // Hash variants: fold shift and odd multiplier per table.
  localparam int          HASH0_SH  = 16;
  localparam logic [31:0] HASH0_MUL = 32'h045D9F3B;
  localparam int          HASH1_SH  = 13;
  localparam logic [31:0] HASH1_MUL = 32'h2C1B3C6D;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_KICK = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/cuckoo_hash.sv
module cuckoo_hash
  import cuckoo_kv_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int IDX_W = 4,
  parameter int SEL   = 0
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  logic [KEY_W-1:0] folded;
  logic [KEY_W-1:0] prod;

  if (SEL == 0) begin : g_h0
    assign folded = key ^ (key >> HASH0_SH);
    assign prod   = folded * KEY_W'(HASH0_MUL);
  end else begin : g_h1
    assign folded = key ^ (key >> HASH1_SH);
    assign prod   = folded * KEY_W'(HASH1_MUL);
  end

  assign idx = prod[KEY_W-1 -: IDX_W];
endmodule

// File: rtl/cuckoo_bank.sv
module cuckoo_bank #(
  parameter int KEY_W = 32,
  parameter int VAL_W = 32,
  parameter int IDX_W = 4,
  localparam int ENT_W = 1 + KEY_W + VAL_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_addr,
  output logic [ENT_W-1:0] lk_q,
  input  logic [IDX_W-1:0] c_addr,
  output logic [ENT_W-1:0] c_q,
  input  logic             we,
  input  logic [ENT_W-1:0] wd
);
  logic [ENT_W-1:0] mem [DEPTH];

  // Control side reads combinationally; lookup side is registered.
  assign c_q = mem[c_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      lk_q <= '0;
    end else begin
      lk_q <= mem[lk_addr];
      if (we) mem[c_addr] <= wd;
    end
  end
endmodule

// File: rtl/cuckoo_lookup.sv
module cuckoo_lookup
  import cuckoo_kv_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int VAL_W = 32,
  localparam int ENT_W = 1 + KEY_W + VAL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  input  logic [KEY_W-1:0]            lk_key,
  input  logic [N_TBL-1:0][ENT_W-1:0] slot_q,
  input  logic                        carry_v,
  input  logic [KEY_W-1:0]            carry_key,
  input  logic [VAL_W-1:0]            carry_val,
  output logic                        res_valid,
  output logic                        res_hit,
  output logic [VAL_W-1:0]            res_value
);
  logic             s1_v, s1_cv;
  logic [KEY_W-1:0] s1_key, s1_ck;
  logic [VAL_W-1:0] s1_cval;
  logic [N_TBL-1:0] t_hit;
  logic             c_hit, any_hit;
  logic [VAL_W-1:0] pick;

  for (genvar g = 0; g < N_TBL; g++) begin : g_cmp
    assign t_hit[g] = slot_q[g][ENT_W-1] &&
                      (slot_q[g][KEY_W+VAL_W-1:VAL_W] == s1_key);
  end
  assign c_hit   = s1_cv && (s1_ck == s1_key);
  assign any_hit = |t_hit || c_hit;

  always_comb begin
    pick = '0;
    if (t_hit[0])      pick = slot_q[0][VAL_W-1:0];
    else if (t_hit[1]) pick = slot_q[1][VAL_W-1:0];
    else if (c_hit)    pick = s1_cval;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_key <= '0; s1_cv <= 1'b0; s1_ck <= '0; s1_cval <= '0;
      res_valid <= 1'b0; res_hit <= 1'b0; res_value <= '0;
    end else begin
      s1_v      <= lk_valid;
      s1_key    <= lk_key;
      s1_cv     <= carry_v;
      s1_ck     <= carry_key;
      s1_cval   <= carry_val;
      res_valid <= s1_v;
      res_hit   <= s1_v && any_hit;
      res_value <= (s1_v && any_hit) ? pick : '0;
    end
  end
endmodule

// File: rtl/cuckoo_ctrl.sv
module cuckoo_ctrl
  import cuckoo_kv_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int VAL_W     = 32,
  parameter int MAX_KICKS = 16,
  localparam int ENT_W = 1 + KEY_W + VAL_W,
  localparam int KC_W  = $clog2(MAX_KICKS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_del,
  input  logic [KEY_W-1:0]            req_key,
  input  logic [VAL_W-1:0]            req_value,
  output logic [KEY_W-1:0]            probe_key,
  input  logic [N_TBL-1:0][ENT_W-1:0] slot_q,
  output logic [N_TBL-1:0]            slot_we,
  output logic [N_TBL-1:0][ENT_W-1:0] slot_wd,
  output logic                        carry_v,
  output logic [KEY_W-1:0]            carry_key,
  output logic [VAL_W-1:0]            carry_val,
  output logic                        op_done,
  output logic                        op_found,
  output logic                        op_fail
);
  ctl_state_e       state, n_state;
  logic             op_del, c_tbl, n_tbl;
  logic [KEY_W-1:0] op_key, c_key, n_key;
  logic [VAL_W-1:0] op_val, c_val, n_val;
  logic [KC_W-1:0]  kicks, n_kicks;
  logic             n_done, n_found, n_fail;

  logic [N_TBL-1:0]            s_v, hit;
  logic [N_TBL-1:0][KEY_W-1:0] s_k;
  logic [N_TBL-1:0][VAL_W-1:0] s_val;

  assign probe_key = (state == ST_KICK) ? c_key : op_key;
  assign req_ready = (state == ST_IDLE);
  assign carry_v   = (state == ST_KICK);
  assign carry_key = c_key;
  assign carry_val = c_val;

  for (genvar g = 0; g < N_TBL; g++) begin : g_slot
    assign s_v[g]   = slot_q[g][ENT_W-1];
    assign s_k[g]   = slot_q[g][KEY_W+VAL_W-1:VAL_W];
    assign s_val[g] = slot_q[g][VAL_W-1:0];
    assign hit[g]   = s_v[g] && (s_k[g] == probe_key);
  end

  always_comb begin
    slot_we = '0;
    slot_wd = '0;
    n_state = state;
    n_key = c_key; n_val = c_val; n_tbl = c_tbl; n_kicks = kicks;
    n_done = 1'b0; n_found = 1'b0; n_fail = 1'b0;
    unique case (state)
      ST_IDLE: if (req_valid) n_state = ST_EXEC;
      ST_EXEC: begin
        n_state = ST_IDLE;
        n_done  = 1'b1;
        if (op_del) begin
          for (int t = 0; t < N_TBL; t++) slot_wd[t] = {1'b0, slot_q[t][ENT_W-2:0]};
          if (hit[0])      begin slot_we[0] = 1'b1; n_found = 1'b1; end
          else if (hit[1]) begin slot_we[1] = 1'b1; n_found = 1'b1; end
        end else begin
          for (int t = 0; t < N_TBL; t++) slot_wd[t] = {1'b1, op_key, op_val};
          if (hit[0])       begin slot_we[0] = 1'b1; n_found = 1'b1; end
          else if (hit[1])  begin slot_we[1] = 1'b1; n_found = 1'b1; end
          else if (!s_v[0]) slot_we[0] = 1'b1;
          else if (!s_v[1]) slot_we[1] = 1'b1;
          else begin
            slot_we[0] = 1'b1;
            n_key   = s_k[0];
            n_val   = s_val[0];
            n_tbl   = 1'b1;
            n_kicks = KC_W'(1);
            n_state = ST_KICK;
            n_done  = 1'b0;
          end
        end
      end
      ST_KICK: begin
        for (int t = 0; t < N_TBL; t++) slot_wd[t] = {1'b1, c_key, c_val};
        if (!s_v[c_tbl]) begin
          slot_we[c_tbl] = 1'b1;
          n_state = ST_IDLE;
          n_done  = 1'b1;
        end else if (kicks < KC_W'(MAX_KICKS)) begin
          slot_we[c_tbl] = 1'b1;
          n_key   = s_k[c_tbl];
          n_val   = s_val[c_tbl];
          n_tbl   = ~c_tbl;
          n_kicks = kicks + 1'b1;
        end else begin
          n_state = ST_IDLE;
          n_done  = 1'b1;
          n_fail  = 1'b1;
        end
      end
      default: n_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_del <= 1'b0; op_key <= '0; op_val <= '0;
      c_key <= '0; c_val <= '0; c_tbl <= 1'b0; kicks <= '0;
      op_done <= 1'b0; op_found <= 1'b0; op_fail <= 1'b0;
    end else begin
      state <= n_state;
      if (state == ST_IDLE && req_valid) begin
        op_del <= req_del;
        op_key <= req_key;
        op_val <= req_value;
      end
      c_key <= n_key; c_val <= n_val; c_tbl <= n_tbl; kicks <= n_kicks;
      op_done  <= n_done;
      op_found <= n_found;
      op_fail  <= n_fail;
    end
  end
endmodule

// File: rtl/cuckoo_kv.sv
module cuckoo_kv
  import cuckoo_kv_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int VAL_W     = 32,
  parameter int IDX_W     = 4,
  parameter int MAX_KICKS = 16,
  localparam int ENT_W = 1 + KEY_W + VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_key,
  output logic             res_valid,
  output logic             res_hit,
  output logic [VAL_W-1:0] res_value,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_del,
  input  logic [KEY_W-1:0] req_key,
  input  logic [VAL_W-1:0] req_value,
  output logic             op_done,
  output logic             op_found,
  output logic             op_fail
);
  logic [N_TBL-1:0][IDX_W-1:0] lk_idx, pr_idx;
  logic [N_TBL-1:0][ENT_W-1:0] lk_q, c_q, wd;
  logic [N_TBL-1:0]            we;
  logic [KEY_W-1:0]            probe_key, carry_key;
  logic [VAL_W-1:0]            carry_val;
  logic                        carry_v;

  for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
    cuckoo_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SEL(g)) u_lk_hash (
      .key(lk_key), .idx(lk_idx[g]));
    cuckoo_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .SEL(g)) u_pr_hash (
      .key(probe_key), .idx(pr_idx[g]));
    cuckoo_bank #(.KEY_W(KEY_W), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(lk_idx[g]), .lk_q(lk_q[g]),
      .c_addr(pr_idx[g]), .c_q(c_q[g]),
      .we(we[g]), .wd(wd[g]));
  end

  cuckoo_lookup #(.KEY_W(KEY_W), .VAL_W(VAL_W)) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_key(lk_key), .slot_q(lk_q),
    .carry_v(carry_v), .carry_key(carry_key), .carry_val(carry_val),
    .res_valid(res_valid), .res_hit(res_hit), .res_value(res_value));

  cuckoo_ctrl #(.KEY_W(KEY_W), .VAL_W(VAL_W), .MAX_KICKS(MAX_KICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_del(req_del),
    .req_key(req_key), .req_value(req_value),
    .probe_key(probe_key), .slot_q(c_q), .slot_we(we), .slot_wd(wd),
    .carry_v(carry_v), .carry_key(carry_key), .carry_val(carry_val),
    .op_done(op_done), .op_found(op_found), .op_fail(op_fail));
endmodule

// File: rtl/cuckoo_kv_chk.sv
module cuckoo_kv_chk #(
  parameter int VAL_W     = 32,
  parameter int MAX_KICKS = 16,
  localparam int BC_W = $clog2(MAX_KICKS + 4) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [VAL_W-1:0] res_value,
  input logic             req_valid,
  input logic             req_ready,
  input logic             op_done,
  input logic             op_found,
  input logic             op_fail
);
  logic [1:0]      age;
  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age      <= '0;
      busy_cnt <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      busy_cnt <= req_ready ? '0 : busy_cnt + 1'b1;
    end
  end

  p_res_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (res_valid == $past(lk_valid, 2)));

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_value == '0));

  p_result_only_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> req_ready);

  p_flags_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_found || op_fail) |-> (op_done && !(op_found && op_fail)));

  p_chain_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BC_W'(MAX_KICKS + 1));
endmodule

bind cuckoo_kv cuckoo_kv_chk #(.VAL_W(VAL_W), .MAX_KICKS(MAX_KICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_value(res_value), .req_valid(req_valid),
  .req_ready(req_ready), .op_done(op_done), .op_found(op_found),
  .op_fail(op_fail));

// File: tb/test_cuckoo_kv.sv
`timescale 1ns/1ps
module test_cuckoo_kv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_key = '0;
  logic        res_valid, res_hit;
  logic [31:0] res_value;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_del = 1'b0;
  logic [31:0] req_key = '0;
  logic [31:0] req_value = '0;
  logic        op_done, op_found, op_fail;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cuckoo_kv i_cuckoo_kv (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_value(res_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_del(req_del),
    .req_key(req_key), .req_value(req_value),
    .op_done(op_done), .op_found(op_found), .op_fail(op_fail));

  function automatic logic [3:0] bh(input int sel, input logic [31:0] k);
    logic [31:0] p;
    if (sel == 0) p = (k ^ (k >> 16)) * 32'h045D9F3B;
    else          p = (k ^ (k >> 13)) * 32'h2C1B3C6D;
    return p[31:28];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_valid = 1'b0; req_valid = 1'b0; req_del = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_req(input bit del, input logic [31:0] key, input logic [31:0] val,
                        output int lat, output bit found, output bit fail);
    @(negedge clk);
    req_valid = 1'b1; req_del = del; req_key = key; req_value = val;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!op_done && lat < 40);
    found = op_found;
    fail  = op_fail;
  endtask

  task automatic lookup1(input logic [31:0] key, output bit hit, output logic [31:0] val);
    @(negedge clk);
    lk_valid = 1'b1; lk_key = key;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    hit = res_hit && res_valid;
    val = res_value;
  endtask

  task automatic t_reset();
    int lat; bit f, fl, h; logic [31:0] v;
    do_reset();
    chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
    chk(res_valid == 1'b0 && op_done == 1'b0, "R11 outputs idle", {res_valid, op_done}, 0);
    do_req(1'b0, 32'h0000_1234, 32'hABCD, lat, f, fl);
    do_reset();
    lookup1(32'h0000_1234, h, v);
    chk(h == 1'b0, "R11 table empty after reset", h, 0);
  endtask

  task automatic t_basic();
    int lat; bit f, fl, h; logic [31:0] v;
    do_reset();
    do_req(1'b0, 32'h0000_00A1, 32'h1111_0001, lat, f, fl);
    chk(lat == 1 && !f && !fl, "R4 insert latency/status", {lat, f, fl}, {32'd1, 2'b00});
    lookup1(32'h0000_00A1, h, v);
    chk(h && v == 32'h1111_0001, "R2 hit value", v, 32'h1111_0001);
    lookup1(32'h0000_00B7, h, v);
    chk(!h && v == 0, "R2 miss reports zero", {h, v}, 0);
    do_req(1'b0, 32'h0000_00A1, 32'h2222_0002, lat, f, fl);
    chk(lat == 1 && f && !fl, "R5 update in place status", {lat, f, fl}, {32'd1, 2'b10});
    lookup1(32'h0000_00A1, h, v);
    chk(h && v == 32'h2222_0002, "R5 updated value", v, 32'h2222_0002);
  endtask

  task automatic t_pipe();
    int lat; bit f, fl; int nres;
    logic [31:0] keys [6];
    do_reset();
    for (int i = 0; i < 6; i++) keys[i] = 32'h0300_0000 + i * 32'h101;
    for (int i = 0; i < 6; i += 2) do_req(1'b0, keys[i], keys[i] ^ 32'h5A5A, lat, f, fl);
    nres = 0;
    for (int c = 0; c < 9; c++) begin
      @(negedge clk);
      if (c >= 2 && c < 8) begin
        chk(res_valid == 1'b1, "R1 back-to-back result valid", res_valid, 1);
        if ((c - 2) % 2 == 0)
          chk(res_hit && res_value == (keys[c-2] ^ 32'h5A5A), "R1 R2 stream hit",
              res_value, keys[c-2] ^ 32'h5A5A);
        else
          chk(!res_hit && res_value == 0, "R1 R2 stream miss", res_value, 0);
        nres++;
      end else if (c < 2 || c == 8) begin
        chk(res_valid == 1'b0, "R1 no stray result", res_valid, 0);
      end
      if (c < 6) begin lk_valid = 1'b1; lk_key = keys[c]; end
      else lk_valid = 1'b0;
    end
    chk(nres == 6, "R1 result count", nres, 6);
  endtask

  task automatic t_evict();
    int lat, zlat, nres; bit f, fl, h; logic [31:0] v;
    logic [31:0] kx, ky, kz;
    do_reset();
    kx = 32'h0000_7001;
    ky = 0; kz = 0;
    for (int k = 1; k < 200000; k++) begin
      logic [31:0] c;
      c = 32'h0100_0000 + k;
      if (ky == 0 && bh(0, c) == bh(0, kx) && bh(1, c) != bh(1, kx)) ky = c;
      else if (ky != 0 && c != ky && bh(0, c) == bh(0, kx) && bh(1, c) == bh(1, ky)) begin
        kz = c;
        break;
      end
    end
    do_req(1'b0, kx, 32'hF00D_0001, lat, f, fl);
    do_req(1'b0, ky, 32'hF00D_0002, lat, f, fl);
    chk(lat == 1 && !f && !fl, "R4 second slot insert", {lat, f, fl}, {32'd1, 2'b00});
    // Insert kz while looking up kx on every cycle (bypass through the carry)
    @(negedge clk);
    req_valid = 1'b1; req_del = 1'b0; req_key = kz; req_value = 32'hF00D_0003;
    lk_valid = 1'b1; lk_key = kx;
    nres = 0; zlat = -1;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 0) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy during chain", req_ready, 0);
      end
      if (c == 5) lk_valid = 1'b0;
      if (res_valid) begin
        nres++;
        chk(res_hit && res_value == 32'hF00D_0001, "R9 displaced key visible", res_value, 32'hF00D_0001);
      end
      if (op_done && zlat < 0) begin
        zlat = c;
        chk(!op_found && !op_fail, "R6 chain status", {op_found, op_fail}, 0);
      end
    end
    chk(nres == 6, "R9 lookups during chain", nres, 6);
    chk(zlat == 2, "R6 R3 one-step chain latency", zlat, 2);
    lookup1(kx, h, v); chk(h && v == 32'hF00D_0001, "R6 relocated key", v, 32'hF00D_0001);
    lookup1(ky, h, v); chk(h && v == 32'hF00D_0002, "R6 untouched key", v, 32'hF00D_0002);
    lookup1(kz, h, v); chk(h && v == 32'hF00D_0003, "R6 new key", v, 32'hF00D_0003);
    do_req(1'b1, ky, 0, lat, f, fl);
    chk(lat == 1 && f, "R10 delete found", {lat, f}, {32'd1, 1'b1});
    lookup1(ky, h, v); chk(!h, "R10 deleted key misses", h, 0);
    lookup1(kx, h, v); chk(h && v == 32'hF00D_0001, "R10 other key kept", v, 32'hF00D_0001);
    do_req(1'b1, ky, 0, lat, f, fl);
    chk(!f, "R10 delete absent", f, 0);
    lookup1(kz, h, v); chk(h && v == 32'hF00D_0003, "R10 absent delete no effect", v, 32'hF00D_0003);
  endtask

  task automatic t_fail();
    int lat, n, nhit; bit f, fl, seen, h; logic [31:0] v;
    do_reset();
    n = 0; seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      do_req(1'b0, 32'hA000_0000 + i * 32'h9E37, (32'hA000_0000 + i * 32'h9E37) ^ 32'h5555, lat, f, fl);
      n++;
      if (fl) begin
        seen = 1'b1;
        chk(lat == 17 && !f, "R7 abort latency/status", {lat, f}, {32'd17, 1'b0});
        break;
      end
    end
    chk(seen, "R7 abort reached", seen, 1);
    nhit = 0;
    for (int i = 0; i < n; i++) begin
      lookup1(32'hA000_0000 + i * 32'h9E37, h, v);
      if (h) begin
        nhit++;
        chk(v == ((32'hA000_0000 + i * 32'h9E37) ^ 32'h5555), "R7 surviving value", v,
            (32'hA000_0000 + i * 32'h9E37) ^ 32'h5555);
      end
    end
    chk(nhit == n - 1, "R7 exactly one pair dropped", nhit, n - 1);
    chk(req_ready == 1'b1, "R8 idle after abort", req_ready, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_pipe();
    t_evict();
    t_fail();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule